// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock and bypass decision logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the source registers of the instruction in decode and at the destination, write-enable and load flags of the instructions in execute, memory and write-back. From these it decides whether fetch and decode must hold, whether a bubble enters execute, which younger slots are squashed after a taken branch, and where each operand should come from. The register file, ALU, memories and the operand multiplexers sit outside the block and follow its selects.

Two branch styles are supported. A branch that tests one register against zero is resolved in decode. It squashes only the fetch slot when taken, and its compare operand has its own bypass and interlock rules. Every other branch is resolved in execute and squashes both fetch and decode. A mode input turns bypassing off. The decode instruction then waits until its producer has written the register file. A second input states whether the register file writes before it reads within one cycle. With bypassing on, the register file is assumed to return a value written in the same cycle.

The execute-operand selects and the enables passed into execute are registered at the decode-to-execute boundary. They change one clock after the decode inputs that produce them. The stall, bubble, flush and compare-select outputs are combinational.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With bypassing on, a decode source matching an ALU producer never stalls. One clock later the execute select for that operand reads 2'b01 (EX/MEM latch) when the producer was in execute. It reads 2'b10 (MEM/WB latch) when the producer was in memory, and 2'b00 (register file) otherwise.
- R2: When the producers in both execute and memory match the same decode source, the registered select is 2'b01, so the younger result wins.
- R3: Register 0 is never a hazard or bypass source. A source of 0 gives no stall and a registered select of 2'b00, whatever writes register 0.
- R4: With bypassing on, a load in execute whose destination matches a used decode source raises stall_fetch and bubble_ex for exactly that cycle. When the load has moved to memory there is no stall, and the next registered select is 2'b10.
- R5: With bypassing off and the register file writing before reading, a matching producer in execute or memory stalls decode. A match in write-back does not, so a load directly ahead costs two bubbles. All execute selects read 2'b00 in this mode.
- R6: With bypassing off and no write-before-read, a match in write-back also stalls, so a load directly ahead costs three bubbles.
- R7: A taken branch in execute raises flush_if, flush_id and bubble_ex in the same cycle.
- R8: A taken zero-compare branch in decode with no pending hazard raises flush_if only. flush_id and bubble_ex stay low.
- R9: For the decode zero compare with bypassing on, the following rules apply. A matching producer in execute, ALU or load, stalls. A matching load in memory stalls. A matching ALU op in memory gives zcmp_sel 2'b01. A match in write-back gives zcmp_sel 2'b10. An ALU producer therefore costs one stall and a load costs two.
- R10: A flush wins over a stall. With a taken execute branch, stall_fetch is low even when decode has a hazard. A stalled zero-compare branch does not raise flush_if.
- R11: One clock after a bubble, idex_rf_we and idex_mem_we are 0. Otherwise they copy the decode enables of a valid decode instruction.
- R12: A synchronous active-low reset clears both execute selects and both execute enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_en | input | 1 | 1 = bypassing enabled |
| rf_wr_first | input | 1 | 1 = register file writes before it reads within a cycle |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_rs1 | input | 5 | Decode first source register |
| id_rs2 | input | 5 | Decode second source register |
| id_use_rs1 | input | 1 | Decode reads the first source in execute |
| id_use_rs2 | input | 1 | Decode reads the second source in execute |
| id_zero_br | input | 1 | Decode holds a zero-compare branch on the first source |
| id_zero_taken | input | 1 | Outcome of the decode zero compare |
| id_rf_we | input | 1 | Decode instruction writes a register |
| id_mem_we | input | 1 | Decode instruction writes memory |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_rd | input | 5 | Execute destination register |
| ex_rf_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_br_taken | input | 1 | Execute branch resolved taken |
| mem_valid | input | 1 | Memory slot holds an instruction |
| mem_rd | input | 5 | Memory destination register |
| mem_rf_we | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| wb_valid | input | 1 | Write-back slot holds an instruction |
| wb_rd | input | 5 | Write-back destination register |
| wb_rf_we | input | 1 | Write-back instruction writes a register |
| stall_fetch | output | 1 | Hold PC and the fetch/decode latch |
| bubble_ex | output | 1 | Load a bubble into the decode/execute latch |
| flush_if | output | 1 | Squash the fetch slot |
| flush_id | output | 1 | Squash the decode slot |
| fwd_sel_a | output | 2 | Registered first execute operand select |
| fwd_sel_b | output | 2 | Registered second execute operand select |
| zcmp_sel | output | 2 | Decode zero-compare operand select |
| idex_rf_we | output | 1 | Registered register-write enable for execute |
| idex_mem_we | output | 1 | Registered memory-write enable for execute |

## Verification
The case that needs care is a taken branch in execute in the same cycle as a decode interlock. Both pull on the fetch and decode latches: the stall wants to hold them and the flush wants to clear them. A directed case places a taken execute branch beside a non-bypassed dependence in memory. Another places a taken zero-compare branch behind an execute-stage producer of its operand. The bench judges these by stall_fetch staying low under the flush, flush_if staying low under the stall, and bubble_ex still keeping the execute enables clear on the next clock. Random cycles with register numbers drawn from a small set make such collisions frequent, and a bench model checks every output.

// File: rtl/hz_pkg.sv
// Shared types of the hazard controller.
// Assumes architectural registers are addressed with REG_AW bits and that
// register 0 is hard-wired to zero.
package hz_pkg;
    parameter int unsigned REG_AW = 5;

    // Operand source for execute and for the decode zero compare
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_EXMEM = 2'b01,
        SEL_MEMWB = 2'b10
    } fwd_sel_e;

    // Producer description of one older pipeline stage
    typedef struct packed {
        logic              vld;
        logic              wen;
        logic [REG_AW-1:0] rd;
    } prod_t;
endpackage

// File: rtl/hz_src_match.sv
// Compares one decode source with one older producer.
// Assumes 'used' already includes decode validity; register 0 never matches.
module hz_src_match
    import hz_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  logic              used,
    input  prod_t             prod,
    output logic              hit
);
    // Producer writes the same non-zero register the consumer reads
    assign hit = used & (|src) & prod.vld & prod.wen & (prod.rd == src);
endmodule

// File: rtl/hz_operand_check.sv
// Interlock and bypass decision for one execute operand.
// hit[0]/hit[1]/hit[2] are matches against execute/memory/write-back.
// The select is the one the operand needs once this instruction sits in execute.
module hz_operand_check
    import hz_pkg::*;
#(
    parameter int unsigned NSTG = 3
) (
    input  logic [NSTG-1:0] hit,
    input  logic            ex_ld,
    input  logic            fwd_on,
    input  logic            rf_wr_first,
    output logic            hold,
    output fwd_sel_e        nxt_sel
);
    // Bypassed mode waits only on a load; otherwise wait for the write
    always_comb begin
        if (fwd_on) begin
            hold    = hit[0] & ex_ld;
            nxt_sel = hit[0] ? SEL_EXMEM : (hit[1] ? SEL_MEMWB : SEL_RF);
        end else begin
            hold    = hit[0] | hit[1] | (hit[2] & ~rf_wr_first);
            nxt_sel = SEL_RF;
        end
    end
endmodule

// File: rtl/hz_zero_check.sv
// Interlock and bypass decision for the decode zero compare.
// The compare runs in decode, so an execute producer is never ready and a
// load in memory has no data yet; an ALU result in memory is on EX/MEM.
module hz_zero_check
    import hz_pkg::*;
#(
    parameter int unsigned NSTG = 3
) (
    input  logic [NSTG-1:0] hit,
    input  logic            mem_ld,
    input  logic            fwd_on,
    input  logic            rf_wr_first,
    output logic            hold,
    output fwd_sel_e        zsel
);
    // Pick the youngest ready source or hold decode
    always_comb begin
        if (fwd_on) begin
            hold = hit[0] | (hit[1] & mem_ld);
            if (hit[1] & ~mem_ld)
                zsel = SEL_EXMEM;
            else if (hit[2])
                zsel = SEL_MEMWB;
            else
                zsel = SEL_RF;
        end else begin
            hold = hit[0] | hit[1] | (hit[2] & ~rf_wr_first);
            zsel = SEL_RF;
        end
    end
endmodule

// File: rtl/hz_flush_ctl.sv
// Merges interlock and redirect requests into latch controls.
// A taken execute branch squashes fetch and decode and overrides a stall;
// a decode branch redirects only when its operand is ready.
module hz_flush_ctl (
    input  logic id_valid,
    input  logic zbr,
    input  logic ztaken,
    input  logic ex_taken,
    input  logic hazard,
    output logic stall,
    output logic bubble,
    output logic flush_if,
    output logic flush_id
);
    // Flush wins over stall; bubble covers both a stall and a squashed decode
    always_comb begin
        flush_id = ex_taken;
        flush_if = ex_taken | (id_valid & zbr & ztaken & ~hazard);
        stall    = hazard & ~ex_taken;
        bubble   = hazard | ex_taken;
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard, flush and bypass controller of a five-stage in-order pipeline.
// Assumes the register file returns a same-cycle write when bypassing is on,
// and that a zero-compare branch reads only its first source in decode.
module pipe_hazard_ctrl
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_en,
    input  logic              rf_wr_first,
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              id_zero_br,
    input  logic              id_zero_taken,
    input  logic              id_rf_we,
    input  logic              id_mem_we,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_rf_we,
    input  logic              ex_load,
    input  logic              ex_br_taken,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_rf_we,
    input  logic              mem_load,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_rf_we,
    output logic              stall_fetch,
    output logic              bubble_ex,
    output logic              flush_if,
    output logic              flush_id,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic [1:0]        zcmp_sel,
    output logic              idex_rf_we,
    output logic              idex_mem_we
);
    localparam int unsigned NSTG = 3;        // execute, memory, write-back
    localparam int unsigned NOPS = 2;        // execute operands
    localparam int unsigned NSRC = NOPS + 1; // plus the zero compare
    localparam int unsigned ZIDX = NOPS;

    prod_t                  stg [NSTG];
    logic [REG_AW-1:0]      src [NSRC];
    logic [NSRC-1:0]        src_used;
    logic [NSRC*NSTG-1:0]   hit_flat;
    logic [NOPS-1:0]        op_hold;
    fwd_sel_e               op_sel [NOPS];
    fwd_sel_e               sel_q  [NOPS];
    logic                   z_hold;
    fwd_sel_e               z_sel;
    logic                   hazard;
    logic                   ex_taken;

    // Producer view of the three older stages
    assign stg[0] = '{vld: ex_valid,  wen: ex_rf_we,  rd: ex_rd};
    assign stg[1] = '{vld: mem_valid, wen: mem_rf_we, rd: mem_rd};
    assign stg[2] = '{vld: wb_valid,  wen: wb_rf_we,  rd: wb_rd};

    // Consumer view: two execute operands and the decode compare
    assign src[0]      = id_rs1;
    assign src[1]      = id_rs2;
    assign src[ZIDX]   = id_rs1;
    assign src_used[0] = id_valid & id_use_rs1 & ~id_zero_br;
    assign src_used[1] = id_valid & id_use_rs2 & ~id_zero_br;
    assign src_used[ZIDX] = id_valid & id_zero_br;

    // One comparator per consumer and producer pair
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar t = 0; t < NSTG; t++) begin : g_stg
            hz_src_match u_match (
                .src  (src[s]),
                .used (src_used[s]),
                .prod (stg[t]),
                .hit  (hit_flat[s*NSTG + t])
            );
        end
    end

    // Per-operand interlock and bypass choice
    for (genvar o = 0; o < NOPS; o++) begin : g_op
        hz_operand_check #(.NSTG(NSTG)) u_op (
            .hit         (hit_flat[o*NSTG +: NSTG]),
            .ex_ld       (ex_load),
            .fwd_on      (fwd_en),
            .rf_wr_first (rf_wr_first),
            .hold        (op_hold[o]),
            .nxt_sel     (op_sel[o])
        );
    end

    hz_zero_check #(.NSTG(NSTG)) u_zero (
        .hit         (hit_flat[ZIDX*NSTG +: NSTG]),
        .mem_ld      (mem_load),
        .fwd_on      (fwd_en),
        .rf_wr_first (rf_wr_first),
        .hold        (z_hold),
        .zsel        (z_sel)
    );

    // Any unready source holds decode
    assign hazard   = (|op_hold) | z_hold;
    assign ex_taken = ex_valid & ex_br_taken;

    hz_flush_ctl u_flush (
        .id_valid (id_valid),
        .zbr      (id_zero_br),
        .ztaken   (id_zero_taken),
        .ex_taken (ex_taken),
        .hazard   (hazard),
        .stall    (stall_fetch),
        .bubble   (bubble_ex),
        .flush_if (flush_if),
        .flush_id (flush_id)
    );

    // Decode-to-execute latch of selects and enables; bubbles carry no writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NOPS; o++) sel_q[o] <= SEL_RF;
            idex_rf_we  <= 1'b0;
            idex_mem_we <= 1'b0;
        end else begin
            for (int o = 0; o < NOPS; o++)
                sel_q[o] <= bubble_ex ? SEL_RF : op_sel[o];
            idex_rf_we  <= ~bubble_ex & id_valid & id_rf_we;
            idex_mem_we <= ~bubble_ex & id_valid & id_mem_we;
        end
    end

    assign fwd_sel_a = sel_q[0];
    assign fwd_sel_b = sel_q[1];
    assign zcmp_sel  = z_sel;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
// Property checker for pipe_hazard_ctrl, attached by bind below.
// Relates the decode/stage inputs to the latch controls over time.
module pipe_hazard_ctrl_chk
    import hz_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fwd_en,
    input logic              id_valid,
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] id_rs2,
    input logic              id_use_rs1,
    input logic              id_zero_br,
    input logic              id_zero_taken,
    input logic              ex_valid,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_rf_we,
    input logic              ex_load,
    input logic              ex_br_taken,
    input logic              mem_valid,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_rf_we,
    input logic              stall_fetch,
    input logic              bubble_ex,
    input logic              flush_if,
    input logic              flush_id,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              idex_rf_we,
    input logic              idex_mem_we
);
    assert_eqrd_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && id_valid && id_use_rs1 && !id_zero_br && id_rs1 != '0 &&
         !bubble_ex && ex_valid && ex_rf_we && ex_rd == id_rs1 &&
         mem_valid && mem_rf_we && mem_rd == id_rs1) |=> fwd_sel_a == 2'b01);

    assert_zero_src_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |=> fwd_sel_a == 2'b00);

    assert_zero_src_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs2 == '0) |=> fwd_sel_b == 2'b00);

    assert_load_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && id_valid && id_use_rs1 && !id_zero_br && id_rs1 != '0 &&
         ex_valid && ex_rf_we && ex_load && ex_rd == id_rs1 && !ex_br_taken)
        |-> stall_fetch && bubble_ex);

    assert_ex_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_br_taken) |-> flush_if && flush_id && bubble_ex);

    assert_id_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_if && !flush_id) |-> id_zero_br && id_zero_taken && !stall_fetch);

    assert_flush_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_id |-> !stall_fetch);

    assert_bubble_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex |=> !idex_rf_we && !idex_mem_we);

    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00 &&
                   !idex_rf_we && !idex_mem_we);
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk chk_i (.*);

// File: tb/pipe_hazard_ctrl_tb_top.sv
// Bench for pipe_hazard_ctrl: directed corner cases, then seeded random
// stage contents checked against a model built from the requirements.
module pipe_hazard_ctrl_tb_top;
    localparam int CLK_NS   = 20;
    localparam int N_RAND   = 3000;
    localparam int WDOG_CYC = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic fwd_en, rf_wr_first;
    logic id_valid, id_use_rs1, id_use_rs2, id_zero_br, id_zero_taken, id_rf_we, id_mem_we;
    logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_valid, ex_rf_we, ex_load, ex_br_taken;
    logic mem_valid, mem_rf_we, mem_load;
    logic wb_valid, wb_rf_we;
    logic stall_fetch, bubble_ex, flush_if, flush_id, idex_rf_we, idex_mem_we;
    logic [1:0] fwd_sel_a, fwd_sel_b, zcmp_sel;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // model results
    logic m_stall, m_bubble, m_fif, m_fid, m_rfwe, m_memwe;
    logic [1:0] m_z, m_na, m_nb;
    logic [1:0] e_a, e_b;
    logic e_rfwe, e_memwe;

    always #(CLK_NS/2) clk = ~clk;

    pipe_hazard_ctrl dut_i (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        fwd_en = 1'b1; rf_wr_first = 1'b1;
        id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0;
        id_zero_br = 0; id_zero_taken = 0; id_rf_we = 0; id_mem_we = 0;
        ex_valid = 0; ex_rd = 0; ex_rf_we = 0; ex_load = 0; ex_br_taken = 0;
        mem_valid = 0; mem_rd = 0; mem_rf_we = 0; mem_load = 0;
        wb_valid = 0; wb_rd = 0; wb_rf_we = 0;
    endtask

    function automatic logic hit(input logic [4:0] s, input logic u,
                                 input logic v, input logic w, input logic [4:0] d);
        return u && s != 0 && v && w && d == s;
    endfunction

    // Expected outputs from the requirement rules
    task automatic model();
        logic ua, ub, uz, hae, ham, haw, hbe, hbm, hbw, hze, hzm, hzw, ha, hb, hz, haz, fex;
        ua = id_valid && id_use_rs1 && !id_zero_br;
        ub = id_valid && id_use_rs2 && !id_zero_br;
        uz = id_valid && id_zero_br;
        hae = hit(id_rs1, ua, ex_valid, ex_rf_we, ex_rd);
        ham = hit(id_rs1, ua, mem_valid, mem_rf_we, mem_rd);
        haw = hit(id_rs1, ua, wb_valid, wb_rf_we, wb_rd);
        hbe = hit(id_rs2, ub, ex_valid, ex_rf_we, ex_rd);
        hbm = hit(id_rs2, ub, mem_valid, mem_rf_we, mem_rd);
        hbw = hit(id_rs2, ub, wb_valid, wb_rf_we, wb_rd);
        hze = hit(id_rs1, uz, ex_valid, ex_rf_we, ex_rd);
        hzm = hit(id_rs1, uz, mem_valid, mem_rf_we, mem_rd);
        hzw = hit(id_rs1, uz, wb_valid, wb_rf_we, wb_rd);
        if (fwd_en) begin
            ha = hae && ex_load;                          // R4
            hb = hbe && ex_load;
            hz = hze || (hzm && mem_load);                // R9
            m_z = (hzm && !mem_load) ? 2'b01 : (hzw ? 2'b10 : 2'b00);
        end else begin
            ha = hae || ham || (haw && !rf_wr_first);     // R5, R6
            hb = hbe || hbm || (hbw && !rf_wr_first);
            hz = hze || hzm || (hzw && !rf_wr_first);
            m_z = 2'b00;
        end
        haz = ha || hb || hz;
        fex = ex_valid && ex_br_taken;
        m_stall  = haz && !fex;                           // R10
        m_bubble = haz || fex;
        m_fid    = fex;                                   // R7
        m_fif    = fex || (id_valid && id_zero_br && id_zero_taken && !haz); // R8
        m_na = (m_bubble || !fwd_en) ? 2'b00 : (hae ? 2'b01 : (ham ? 2'b10 : 2'b00)); // R1, R2
        m_nb = (m_bubble || !fwd_en) ? 2'b00 : (hbe ? 2'b01 : (hbm ? 2'b10 : 2'b00));
        m_rfwe  = !m_bubble && id_valid && id_rf_we;      // R11
        m_memwe = !m_bubble && id_valid && id_mem_we;
    endtask

    task automatic chk_ctl(input string tag, input logic st, input logic bu,
                           input logic fi, input logic fd);
        chk(tag, stall_fetch, st);
        chk(tag, bubble_ex, bu);
        chk(tag, flush_if, fi);
        chk(tag, flush_id, fd);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        // R12: reset with busy decode inputs
        rst_n = 1'b0;
        id_valid = 1; id_rf_we = 1; id_mem_we = 1; id_use_rs1 = 1; id_rs1 = 3;
        ex_valid = 1; ex_rf_we = 1; ex_rd = 3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", fwd_sel_a, 2'b00); chk("R12", fwd_sel_b, 2'b00);
        chk("R12", idex_rf_we, 0);    chk("R12", idex_mem_we, 0);
        rst_n = 1'b1;

        // R1: ALU producers in execute and memory
        idle();
        id_valid = 1; id_rf_we = 1; id_use_rs1 = 1; id_rs1 = 5; id_use_rs2 = 1; id_rs2 = 6;
        ex_valid = 1; ex_rf_we = 1; ex_rd = 5;
        mem_valid = 1; mem_rf_we = 1; mem_rd = 6;
        #1 chk_ctl("R1", 0, 0, 0, 0);
        @(negedge clk);
        chk("R1", fwd_sel_a, 2'b01); chk("R1", fwd_sel_b, 2'b10); chk("R11", idex_rf_we, 1);

        // R2: both stages match the same source
        idle();
        id_valid = 1; id_use_rs1 = 1; id_rs1 = 9;
        ex_valid = 1; ex_rf_we = 1; ex_rd = 9;
        mem_valid = 1; mem_rf_we = 1; mem_rd = 9;
        @(negedge clk);
        chk("R2", fwd_sel_a, 2'b01);

        // R3: register 0 written by a load in execute
        idle();
        id_valid = 1; id_use_rs1 = 1; id_use_rs2 = 1;
        ex_valid = 1; ex_rf_we = 1; ex_load = 1; ex_rd = 0;
        mem_valid = 1; mem_rf_we = 1; mem_rd = 0;
        #1 chk_ctl("R3", 0, 0, 0, 0);
        @(negedge clk);
        chk("R3", fwd_sel_a, 2'b00); chk("R3", fwd_sel_b, 2'b00);

        // R4: load-use, one bubble then MEM/WB select
        idle();
        id_valid = 1; id_rf_we = 1; id_mem_we = 1; id_use_rs2 = 1; id_rs2 = 7;
        ex_valid = 1; ex_rf_we = 1; ex_load = 1; ex_rd = 7;
        #1 chk_ctl("R4", 1, 1, 0, 0);
        @(negedge clk);
        chk("R11", idex_rf_we, 0); chk("R11", idex_mem_we, 0);
        ex_valid = 0; mem_valid = 1; mem_rf_we = 1; mem_load = 1; mem_rd = 7;
        #1 chk_ctl("R4", 0, 0, 0, 0);
        @(negedge clk);
        chk("R4", fwd_sel_b, 2'b10); chk("R11", idex_mem_we, 1);

        // R5: no bypass, write-before-read: two bubbles
        idle();
        fwd_en = 0; id_valid = 1; id_use_rs1 = 1; id_rs1 = 8;
        ex_valid = 1; ex_rf_we = 1; ex_load = 1; ex_rd = 8;
        #1 chk("R5", stall_fetch, 1);
        @(negedge clk);
        ex_valid = 0; mem_valid = 1; mem_rf_we = 1; mem_load = 1; mem_rd = 8;
        #1 chk("R5", stall_fetch, 1);
        @(negedge clk);
        mem_valid = 0; wb_valid = 1; wb_rf_we = 1; wb_rd = 8;
        #1 chk("R5", stall_fetch, 0);
        @(negedge clk);
        chk("R5", fwd_sel_a, 2'b00);

        // R6: no bypass, no write-before-read: third bubble
        idle();
        fwd_en = 0; rf_wr_first = 0; id_valid = 1; id_use_rs1 = 1; id_rs1 = 8;
        wb_valid = 1; wb_rf_we = 1; wb_rd = 8;
        #1 chk("R6", stall_fetch, 1); chk("R6", bubble_ex, 1);
        @(negedge clk);
        wb_valid = 0;
        #1 chk("R6", stall_fetch, 0);

        // R7 with R10: taken execute branch over a decode interlock
        @(negedge clk);
        idle();
        fwd_en = 0; id_valid = 1; id_rf_we = 1; id_use_rs1 = 1; id_rs1 = 3;
        mem_valid = 1; mem_rf_we = 1; mem_rd = 3;
        ex_valid = 1; ex_br_taken = 1;
        #1 chk_ctl("R7", 0, 1, 1, 1); chk("R10", stall_fetch, 0);
        @(negedge clk);
        chk("R11", idex_rf_we, 0);

        // R8: decode zero branch taken, operand ready
        idle();
        id_valid = 1; id_zero_br = 1; id_zero_taken = 1; id_rs1 = 4;
        #1 chk_ctl("R8", 0, 0, 1, 0);

        // R9 with R10: zero compare after ALU producer in execute
        @(negedge clk);
        ex_valid = 1; ex_rf_we = 1; ex_rd = 4;
        #1 chk("R9", stall_fetch, 1); chk("R10", flush_if, 0);
        @(negedge clk);
        ex_load = 1;
        #1 chk("R9", stall_fetch, 1);
        @(negedge clk);
        ex_valid = 0; ex_load = 0; mem_valid = 1; mem_rf_we = 1; mem_load = 1; mem_rd = 4;
        #1 chk("R9", stall_fetch, 1);
        @(negedge clk);
        mem_load = 0;
        #1 chk("R9", stall_fetch, 0); chk("R9", zcmp_sel, 2'b01); chk("R8", flush_if, 1);
        @(negedge clk);
        mem_valid = 0; wb_valid = 1; wb_rf_we = 1; wb_rd = 4;
        #1 chk("R9", zcmp_sel, 2'b10);

        // Random phase against the model
        void'($urandom(32'd20240611));
        @(negedge clk);
        idle();
        #1 model();
        e_a = m_na; e_b = m_nb; e_rfwe = m_rfwe; e_memwe = m_memwe;
        for (int i = 0; i < N_RAND; i++) begin
            @(negedge clk);
            chk("R1", fwd_sel_a, e_a); chk("R1", fwd_sel_b, e_b);
            chk("R11", idex_rf_we, e_rfwe); chk("R11", idex_mem_we, e_memwe);
            fwd_en      = ($urandom_range(0, 3) != 0);
            rf_wr_first = $urandom_range(0, 1);
            id_valid    = ($urandom_range(0, 7) != 0);
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            id_use_rs1 = $urandom_range(0, 1); id_use_rs2 = $urandom_range(0, 1);
            id_zero_br = ($urandom_range(0, 3) == 0); id_zero_taken = $urandom_range(0, 1);
            id_rf_we = $urandom_range(0, 1); id_mem_we = $urandom_range(0, 1);
            ex_valid = $urandom_range(0, 1); ex_rd = 5'($urandom_range(0, 3));
            ex_rf_we = $urandom_range(0, 1); ex_load = $urandom_range(0, 1);
            ex_br_taken = ($urandom_range(0, 5) == 0);
            mem_valid = $urandom_range(0, 1); mem_rd = 5'($urandom_range(0, 3));
            mem_rf_we = $urandom_range(0, 1); mem_load = $urandom_range(0, 1);
            wb_valid = $urandom_range(0, 1); wb_rd = 5'($urandom_range(0, 3));
            wb_rf_we = $urandom_range(0, 1);
            #1 model();
            chk("R4", stall_fetch, m_stall); chk("R10", bubble_ex, m_bubble);
            chk("R8", flush_if, m_fif);      chk("R7", flush_id, m_fid);
            chk("R9", zcmp_sel, m_z);
            e_a = m_na; e_b = m_nb; e_rfwe = m_rfwe; e_memwe = m_memwe;
        end
        @(negedge clk);
        chk("R1", fwd_sel_a, e_a); chk("R1", fwd_sel_b, e_b);
        finish_run();
    end
endmodule